// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside an 8-bit processor core and merges five interrupt sources into one request toward the core. The request carries a restart address. Four sources are vectored: one non-maskable edge input of top rank, one maskable edge-latched input, and two maskable level inputs. The fifth source is a plain request line. It carries no vector, and the core answers it through an acknowledge pass-through.

The block holds the three mask bits, the latch for the edge-sensitive maskable input, the interrupt-enable flip-flop and a serial output bit. The core writes an 8-bit control word to set masks, clear the edge latch or drive the serial output. It reads an 8-bit status word holding masks, enable state, pending flags and the serial input level. The core pulses `ack_i` when it takes the current request.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset the three masks are 1 (masked) and the enable flip-flop, the serial output, both edge latches and `req_o` are 0. The status word then reads 8'h07 when `ser_in_i` is 0.
- R2: A rising edge on `trap_i` raises `req_o` with vector 16'h0024 and `vectored_o`=1 one cycle later, whatever the masks and the enable flip-flop hold. One edge gives exactly one service: after the acknowledge, a `trap_i` that stays high does not request again.
- R3: When several sources are eligible, the winner follows this order: trap, then the edge-latched input, then `mid_lvl_i`, then `low_lvl_i`, then `nv_req_i`.
- R4: The vectors are 16'h003C for the edge-latched input, 16'h0034 for `mid_lvl_i` and 16'h002C for `low_lvl_i`. `vectored_o` is 1 for them.
- R5: `mid_lvl_i` and `low_lvl_i` are level-sensitive. Each requests only while it is high, its mask bit is 0 and the enable flip-flop is 1. The request follows the level in the same cycle.
- R6: A rising edge on `hi_edge_i` sets a latch one cycle later, even while that input is masked. The latch shows in status bit 6 and stays set after the input falls. It is cleared when its request is acknowledged or when the control word is written with bit 4 set.
- R7: `nv_req_i` requests only while the enable flip-flop is 1, with `vectored_o`=0 and `vec_o`=0. `nv_ack_o` is high exactly while `ack_i` is high and this source is the selected one.
- R8: `en_set_i` sets the enable flip-flop and `en_clr_i` clears it, with clear winning over set. Acknowledging any request, trap included, clears it.
- R9: Control word bits 2:0 are the masks, with bit 0 for `low_lvl_i`, bit 1 for `mid_lvl_i`, bit 2 for the edge-latched input, and 1 meaning masked. They load only when bit 3 is 1; otherwise the masks keep their value.
- R10: Control word bit 6 enables a serial write: when it is 1, bit 7 is loaded into `ser_out_o`. When it is 0, `ser_out_o` keeps its value.
- R11: Status word layout: bits 2:0 are the masks, bit 3 is the enable flip-flop, bit 4 is the `low_lvl_i` level, bit 5 is the `mid_lvl_i` level, bit 6 is the edge latch, and bit 7 is `ser_in_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_i | input | 1 | Non-maskable edge-triggered interrupt |
| hi_edge_i | input | 1 | Maskable edge-latched interrupt |
| mid_lvl_i | input | 1 | Maskable level interrupt, middle rank |
| low_lvl_i | input | 1 | Maskable level interrupt, low rank |
| nv_req_i | input | 1 | Non-vectored interrupt request |
| en_set_i | input | 1 | Enable-interrupts pulse from the core |
| en_clr_i | input | 1 | Disable-interrupts pulse from the core |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word |
| ser_in_i | input | 1 | Serial input level |
| ack_i | input | 1 | Core accepts the current request |
| status_o | output | 8 | Status word |
| ser_out_o | output | 1 | Serial output bit |
| req_o | output | 1 | Interrupt request to the core |
| vectored_o | output | 1 | Request carries a restart vector |
| vec_o | output | 16 | Restart address, 0 when not vectored |
| nv_ack_o | output | 1 | Acknowledge for the non-vectored source |

## Verification
Several rules are checked by assertions on every cycle:
- a trap edge is followed by a 16'h0024 request;
- an accepted request leaves the enable flip-flop clear;
- the edge latch holds until one of its two clear paths acts;
- masks and serial output stay put when their enable bits are 0;
- a low-rank vector appears only when no higher maskable source is eligible.

Other behaviour needs the bench scenarios. These cover the full priority ladder under many mask and enable combinations, and the one-service-per-edge rule while trap stays high. They also cover the edge latch surviving a masked period and a trap service, and the exact status word layout.

// File: rtl/irq_pkg.sv
package irq_pkg;

    parameter int VEC_W   = 16;
    parameter int N_MASK  = 3;
    parameter int WORD_W  = 8;

    localparam int RST_SHIFT = 3;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_HI,
        SRC_MID,
        SRC_LOW,
        SRC_NV
    } src_e;

    // control word written by the core
    typedef struct packed {
        logic              sdata;
        logic              sdata_en;
        logic              unused;
        logic              hi_clr;
        logic              mask_en;
        logic [N_MASK-1:0] mask;
    } ctl_word_t;

    // status word read by the core
    typedef struct packed {
        logic              sin;
        logic              pend_hi;
        logic              pend_mid;
        logic              pend_low;
        logic              ie;
        logic [N_MASK-1:0] mask;
    } stat_word_t;

    // restart address = (restart number in halves) * 4
    function automatic vec_t restart_addr(input int unsigned halves);
        return vec_t'(halves << (RST_SHIFT - 1));
    endfunction

    function automatic vec_t vector_of(input src_e s);
        case (s)
            SRC_TRAP: return restart_addr(9);
            SRC_HI:   return restart_addr(15);
            SRC_MID:  return restart_addr(13);
            SRC_LOW:  return restart_addr(11);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
(
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    input  logic clr_i,
    output logic pend_o
);
    logic sig_q;
    logic rise;

    assign rise = sig_i & ~sig_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sig_q  <= 1'b0;
            pend_o <= 1'b0;
        end else begin
            sig_q  <= sig_i;
            pend_o <= rise | (pend_o & ~clr_i);
        end
    end
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  ctl_word_t         wdata_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              accept_i,
    output logic [N_MASK-1:0] mask_o,
    output logic              ie_o,
    output logic              sout_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_o <= '1;
            ie_o   <= 1'b0;
            sout_o <= 1'b0;
        end else begin
            if (wr_i && wdata_i.mask_en)
                mask_o <= wdata_i.mask;
            if (wr_i && wdata_i.sdata_en)
                sout_o <= wdata_i.sdata;
            if (accept_i || en_clr_i)
                ie_o <= 1'b0;
            else if (en_set_i)
                ie_o <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
    import irq_pkg::*;
(
    input  logic              trap_pend_i,
    input  logic              hi_pend_i,
    input  logic              mid_i,
    input  logic              low_i,
    input  logic              nv_i,
    input  logic [N_MASK-1:0] mask_i,
    input  logic              ie_i,
    output src_e              src_o
);
    logic [N_MASK-1:0] elig;

    // mask index: 0 low, 1 mid, 2 hi
    assign elig = {hi_pend_i, mid_i, low_i} & ~mask_i & {N_MASK{ie_i}};

    always_comb begin
        if (trap_pend_i)
            src_o = SRC_TRAP;
        else if (elig[2])
            src_o = SRC_HI;
        else if (elig[1])
            src_o = SRC_MID;
        else if (elig[0])
            src_o = SRC_LOW;
        else if (nv_i && ie_i)
            src_o = SRC_NV;
        else
            src_o = SRC_NONE;
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_i,
    input  logic              hi_edge_i,
    input  logic              mid_lvl_i,
    input  logic              low_lvl_i,
    input  logic              nv_req_i,
    input  logic              en_set_i,
    input  logic              en_clr_i,
    input  logic              ctl_wr_i,
    input  logic [WORD_W-1:0] ctl_wdata_i,
    input  logic              ser_in_i,
    input  logic              ack_i,
    output logic [WORD_W-1:0] status_o,
    output logic              ser_out_o,
    output logic              req_o,
    output logic              vectored_o,
    output logic [VEC_W-1:0]  vec_o,
    output logic              nv_ack_o
);
    ctl_word_t         cw;
    stat_word_t        sw;
    src_e              src;
    logic              accept;
    logic              trap_pend;
    logic              hi_pend;
    logic              trap_clr;
    logic              hi_clr;
    logic [N_MASK-1:0] mask;
    logic              ie;

    assign cw       = ctl_word_t'(ctl_wdata_i);
    assign accept   = ack_i && (src != SRC_NONE);
    assign trap_clr = accept && (src == SRC_TRAP);
    assign hi_clr   = (accept && (src == SRC_HI)) || (ctl_wr_i && cw.hi_clr);

    irq_edge_latch trap_lat_i (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (trap_i),
        .clr_i  (trap_clr),
        .pend_o (trap_pend)
    );

    irq_edge_latch hi_lat_i (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (hi_edge_i),
        .clr_i  (hi_clr),
        .pend_o (hi_pend)
    );

    irq_ctl_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (ctl_wr_i),
        .wdata_i  (cw),
        .en_set_i (en_set_i),
        .en_clr_i (en_clr_i),
        .accept_i (accept),
        .mask_o   (mask),
        .ie_o     (ie),
        .sout_o   (ser_out_o)
    );

    irq_prio_sel sel_i (
        .trap_pend_i (trap_pend),
        .hi_pend_i   (hi_pend),
        .mid_i       (mid_lvl_i),
        .low_i       (low_lvl_i),
        .nv_i        (nv_req_i),
        .mask_i      (mask),
        .ie_i        (ie),
        .src_o       (src)
    );

    always_comb begin
        sw.sin      = ser_in_i;
        sw.pend_hi  = hi_pend;
        sw.pend_mid = mid_lvl_i;
        sw.pend_low = low_lvl_i;
        sw.ie       = ie;
        sw.mask     = mask;
    end

    assign status_o   = sw;
    assign req_o      = (src != SRC_NONE);
    assign vectored_o = req_o && (src != SRC_NV);
    assign vec_o      = vector_of(src);
    assign nv_ack_o   = ack_i && (src == SRC_NV);
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              trap_i,
    input logic              hi_edge_i,
    input logic              mid_lvl_i,
    input logic              low_lvl_i,
    input logic              nv_req_i,
    input logic              en_set_i,
    input logic              en_clr_i,
    input logic              ctl_wr_i,
    input logic [WORD_W-1:0] ctl_wdata_i,
    input logic              ser_in_i,
    input logic              ack_i,
    input logic [WORD_W-1:0] status_o,
    input logic              ser_out_o,
    input logic              req_o,
    input logic              vectored_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic              nv_ack_o
);
    assert_trap_edge_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(trap_i) |=> req_o && vectored_o && vec_o == 16'h0024);

    assert_low_rank_R3: assert property (@(posedge clk) disable iff (rst)
        (req_o && vec_o == 16'h002C) |->
            !(status_o[5] && !status_o[1]) && !(status_o[6] && !status_o[2]));

    assert_mid_eligible_R5: assert property (@(posedge clk) disable iff (rst)
        (req_o && vec_o == 16'h0034) |-> status_o[5] && !status_o[1] && status_o[3]);

    assert_hi_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (status_o[6] && !(ack_i && req_o && vec_o == 16'h003C)
            && !(ctl_wr_i && ctl_wdata_i[4])) |=> status_o[6]);

    assert_nv_ack_R7: assert property (@(posedge clk) disable iff (rst)
        nv_ack_o |-> ack_i && req_o && !vectored_o && vec_o == '0);

    assert_accept_clears_ie_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_i && req_o) |=> !status_o[3]);

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr_i && ctl_wdata_i[3]) |=> $stable(status_o[2:0]));

    assert_sout_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(ctl_wr_i && ctl_wdata_i[6]) |=> $stable(ser_out_o));
endmodule

bind irq_vector_unit irq_vector_unit_chk chk_i (.*);

// File: tb/irq_vector_unit_tb_top.sv
module irq_vector_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_i = 0, hi_edge_i = 0, mid_lvl_i = 0, low_lvl_i = 0, nv_req_i = 0;
    logic        en_set_i = 0, en_clr_i = 0, ctl_wr_i = 0, ser_in_i = 0, ack_i = 0;
    logic [7:0]  ctl_wdata_i = '0;
    logic [7:0]  status_o;
    logic        ser_out_o, req_o, vectored_o, nv_ack_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_vector_unit dut_i (.*);

    // {ie, mask[2:0], mid, low, nv, exp_req, exp_vectored, exp_vec[15:0]}
    localparam int NTV = 9;
    localparam logic [24:0] TV [0:NTV-1] = '{
        {1'b1, 3'b000, 3'b111, 2'b11, 16'h0034},
        {1'b1, 3'b000, 3'b011, 2'b11, 16'h002C},
        {1'b1, 3'b000, 3'b001, 2'b10, 16'h0000},
        {1'b1, 3'b010, 3'b110, 2'b11, 16'h002C},
        {1'b1, 3'b011, 3'b110, 2'b00, 16'h0000},
        {1'b1, 3'b011, 3'b111, 2'b10, 16'h0000},
        {1'b0, 3'b000, 3'b111, 2'b00, 16'h0000},
        {1'b1, 3'b001, 3'b010, 2'b00, 16'h0000},
        {1'b1, 3'b001, 3'b111, 2'b11, 16'h0034}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_write(input logic [7:0] w);
        ctl_wr_i = 1'b1;
        ctl_wdata_i = w;
        step();
        ctl_wr_i = 1'b0;
        ctl_wdata_i = '0;
    endtask

    task automatic pulse_en(input logic set);
        en_set_i = set;
        en_clr_i = ~set;
        step();
        en_set_i = 1'b0;
        en_clr_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1 reset state
        #1;
        check("R1 status", status_o, 8'h07);
        check("R1 req", req_o, 1'b0);
        check("R1 sout", ser_out_o, 1'b0);

        // R3 R4 R5 R7 table of priority cases
        for (int i = 0; i < NTV; i++) begin
            ctl_wr_i    = 1'b1;
            ctl_wdata_i = {5'b00001, TV[i][23:21]};
            en_set_i    = TV[i][24];
            en_clr_i    = ~TV[i][24];
            mid_lvl_i   = TV[i][20];
            low_lvl_i   = TV[i][19];
            nv_req_i    = TV[i][18];
            step();
            ctl_wr_i = 0; en_set_i = 0; en_clr_i = 0;
            #1;
            check($sformatf("R3 R5 table %0d req", i), req_o, TV[i][17]);
            check($sformatf("R4 R7 table %0d vectored", i), vectored_o, TV[i][16]);
            check($sformatf("R4 table %0d vec", i), vec_o, TV[i][15:0]);
        end
        mid_lvl_i = 0; low_lvl_i = 0; nv_req_i = 0;

        do_reset();

        // R11 status layout
        ser_in_i = 1; mid_lvl_i = 1; low_lvl_i = 1;
        #1;
        check("R11 status", status_o, 8'hB7);
        ser_in_i = 0; mid_lvl_i = 0; low_lvl_i = 0;

        // R9 mask enable gate
        ctl_write(8'h07);
        check("R9 masks kept", status_o, 8'h07);
        ctl_write(8'h08);
        check("R9 masks loaded", status_o, 8'h00);

        // R8 enable flip-flop
        pulse_en(1'b1);
        check("R8 set", status_o, 8'h08);
        pulse_en(1'b0);
        check("R8 clear", status_o, 8'h00);
        en_set_i = 1; en_clr_i = 1;
        step();
        en_set_i = 0; en_clr_i = 0;
        check("R8 clear wins", status_o[3], 1'b0);
        pulse_en(1'b1);

        // R6 edge latch holds after input falls
        hi_edge_i = 1;
        step();
        hi_edge_i = 0;
        step();
        check("R6 latched", status_o[6], 1'b1);
        check("R4 hi vec", vec_o, 16'h003C);
        mid_lvl_i = 1;
        #1;
        check("R3 hi over mid", vec_o, 16'h003C);

        // R2 R3 trap over everything
        trap_i = 1;
        step();
        check("R2 R3 trap vec", vec_o, 16'h0024);
        check("R2 trap vectored", vectored_o, 1'b1);
        pulse_ack();
        check("R2 one service", req_o, 1'b0);
        check("R8 R6 after trap", status_o, 8'h60);
        trap_i = 0;

        // R6 ack clears latch; R5 level
        pulse_en(1'b1);
        check("R6 hi again", vec_o, 16'h003C);
        pulse_ack();
        check("R6 ack clears", status_o[6], 1'b0);
        pulse_en(1'b1);
        check("R5 mid level", vec_o, 16'h0034);
        mid_lvl_i = 0;
        #1;
        check("R5 follows level", req_o, 1'b0);
        low_lvl_i = 1;
        #1;
        check("R4 low vec", vec_o, 16'h002C);
        low_lvl_i = 0;

        // R6 latch while masked, cleared by control bit 4
        ctl_write(8'h0C);
        hi_edge_i = 1;
        step();
        hi_edge_i = 0;
        check("R6 masked latch", status_o[6], 1'b1);
        check("R6 masked no req", req_o, 1'b0);
        ctl_write(8'h10);
        check("R6 R9 clear bit", status_o, 8'h0C);

        // R7 non-vectored source
        ctl_write(8'h0F);
        nv_req_i = 1;
        #1;
        check("R7 req", req_o, 1'b1);
        check("R7 not vectored", vectored_o, 1'b0);
        check("R7 vec zero", vec_o, 16'h0000);
        ack_i = 1;
        #1;
        check("R7 nv ack", nv_ack_o, 1'b1);
        step();
        ack_i = 0;
        check("R8 ack clears ie", status_o[3], 1'b0);
        check("R7 no req", req_o, 1'b0);
        nv_req_i = 0;

        // R10 serial output
        ctl_write(8'h80);
        check("R10 gated", ser_out_o, 1'b0);
        ctl_write(8'hC0);
        check("R10 set", ser_out_o, 1'b1);
        ctl_write(8'hA0);
        check("R10 kept", ser_out_o, 1'b1);
        ctl_write(8'h40);
        check("R10 cleared", ser_out_o, 1'b0);

        // R2 trap with everything masked and disabled
        trap_i = 1;
        step();
        check("R2 trap ignores masks", vec_o, 16'h0024);
        pulse_ack();
        check("R2 served once", req_o, 1'b0);
        trap_i = 0;
        step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule